// File: doc/BRIEF.md
# Core Sleep Entry and Wake Controller

This block sits beside a processor core and decides when the core may stop its clock and when it has to start again. The core raises a one-cycle strobe for a wait-for-interrupt hint, a wait-for-event hint or an exception return. The block weighs that strobe against the pending interrupt lines and their enables, an external event input, the global priority mask and a small local control register. It then either raises a sleep request or treats the hint as a no-op.

While the core sleeps, the block watches for the wake condition that fits the kind of wait that was entered. When that condition appears it drops the sleep request and issues a one-cycle wake pulse. It also flags whether the core should take an interrupt or simply resume after the wait. A one-bit event latch records wake events that arrive while no wait-for-event sleep is in progress, so that a later wait-for-event returns at once. The control register holds three bits, written through a strobe and data port: bit 0 is send-event-on-pending, bit 1 is sleep-on-exit and bit 2 is deep-sleep. All three are clear after reset.

Top module: `core_sleep_ctrl`

## Requirements
- R1: The control register is clear after reset, so a sleep entered before any write reports ordinary sleep (`deep_o` low). A write with `ctrl_wr_i` high loads bit 0 as send-event-on-pending, bit 1 as sleep-on-exit and bit 2 as deep-sleep, and the new value applies from the next cycle.
- R2: After reset, `sleep_req_o`, `deep_o`, `wake_o` and `take_irq_o` are all low. A wait-for-interrupt strobe with no enabled interrupt pending raises `sleep_req_o` at the next clock edge.
- R3: A sleep entered through wait-for-interrupt ends only when a line is both pending and enabled. A pending line whose enable is low does not end it, and neither does the external event input.
- R4: A sleep entered through wait-for-event ends on a high external event input, or when a line is both pending and enabled.
- R5: While send-event-on-pending is set, a line that goes from not pending to pending counts as a wake event even when its enable is low. It ends a wait-for-event sleep, or it sets the event latch while the core runs. While send-event-on-pending is clear, such a line does neither.
- R6: While sleep-on-exit is set, an exception-return strobe enters sleep exactly as a wait-for-interrupt would, including its wake rules. While sleep-on-exit is clear, the strobe has no effect.
- R7: A wait-for-interrupt or wait-for-event strobe that arrives while any enabled line is pending does not enter sleep. A wait-for-event strobe is also refused while the event latch is set or a wake event arrives in the same cycle.
- R8: A wake event that arrives while running, or during a wait-for-interrupt sleep, sets the event latch. The next wait-for-event strobe clears the latch and returns without sleeping, and the wait-for-event after that sleeps.
- R9: `wake_o` is a registered pulse one cycle wide. `sleep_req_o` falls in the same cycle that `wake_o` rises.
- R10: `take_irq_o` pulses with `wake_o` only when an enabled line is pending and the priority mask is clear. With the mask set, the wake still happens but `take_irq_o` stays low.
- R11: `deep_o` is high only while sleeping, and it equals the deep-sleep bit as it stood when that sleep was entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Wait-for-interrupt hint strobe |
| wfe_i | input | 1 | Wait-for-event hint strobe |
| exc_ret_i | input | 1 | Exception-return strobe |
| irq_pend_i | input | NLINES | Pending flag per interrupt line |
| irq_en_i | input | NLINES | Enable per interrupt line |
| ext_evt_i | input | 1 | External event input |
| primask_i | input | 1 | Global priority mask |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | Control write data: [2] deep-sleep, [1] sleep-on-exit, [0] send-event-on-pending |
| sleep_req_o | output | 1 | Request to halt the core clock |
| deep_o | output | 1 | Deep-sleep qualifier while sleeping |
| wake_o | output | 1 | One-cycle wake pulse |
| take_irq_o | output | 1 | Take the pending interrupt on this wake |

## Verification
Each result is one register away from its cause. A hint strobe shows on `sleep_req_o` and `deep_o` after the next rising edge. A wake cause shows on `wake_o`, `take_irq_o` and the falling `sleep_req_o` after the next rising edge, and `wake_o` is low again one edge later. The bench changes inputs just after a falling edge and reads outputs at the following falling edge, so every check lands exactly one rising edge after its stimulus. When a case must show that nothing happens, the bench holds the stimulus for two edges and then confirms that the sleep request is still high or still low.

// File: rtl/csl_pkg.sv
package csl_pkg;
  localparam int CTRL_W = 3;

  typedef struct packed {
    logic deep;
    logic sleep_on_exit;
    logic sev_on_pend;
  } ctrl_t;

  typedef enum logic {
    MODE_WFI = 1'b0,
    MODE_WFE = 1'b1
  } mode_e;
endpackage

// File: rtl/csl_ctrl_reg.sv
module csl_ctrl_reg
  import csl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;

  assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/csl_wake_detect.sv
module csl_wake_detect #(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pend_i,
  input  logic [NLINES-1:0] en_i,
  input  logic              ext_evt_i,
  input  logic              sev_on_pend_i,
  output logic              irq_act_o,
  output logic              evt_in_o
);
  logic [NLINES-1:0] pend_q;
  logic [NLINES-1:0] rise;
  logic [NLINES-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else pend_q <= pend_i;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign rise[i] = pend_i[i] & ~pend_q[i];
    assign act[i]  = pend_i[i] & en_i[i];
  end

  assign irq_act_o = |act;
  assign evt_in_o  = ext_evt_i | (sev_on_pend_i & (|rise));

  assert_nosev_noevt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sev_on_pend_i && !ext_evt_i) |-> !evt_in_o);
endmodule

// File: rtl/csl_sleep_fsm.sv
module csl_sleep_fsm
  import csl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wfi_i,
  input  logic  wfe_i,
  input  logic  exc_ret_i,
  input  ctrl_t ctrl_i,
  input  logic  irq_act_i,
  input  logic  evt_in_i,
  input  logic  primask_i,
  output logic  sleep_req_o,
  output logic  deep_o,
  output logic  wake_o,
  output logic  take_irq_o
);
  logic  sleep_q, deep_q, wake_q, take_q, evt_q;
  mode_e mode_q;
  logic  wfi_req, wfe_req, wfi_ok, wfe_ok, wake_cond;

  assign wfi_req   = wfi_i | (exc_ret_i & ctrl_i.sleep_on_exit);
  assign wfe_req   = wfe_i & ~wfi_req;
  assign wfi_ok    = wfi_req & ~irq_act_i;
  assign wfe_ok    = wfe_req & ~irq_act_i & ~evt_q & ~evt_in_i;
  assign wake_cond = irq_act_i | ((mode_q == MODE_WFE) & evt_in_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      deep_q  <= 1'b0;
      wake_q  <= 1'b0;
      take_q  <= 1'b0;
      mode_q  <= MODE_WFI;
    end else begin
      wake_q <= 1'b0;
      take_q <= 1'b0;
      if (sleep_q) begin
        if (wake_cond) begin
          sleep_q <= 1'b0;
          deep_q  <= 1'b0;
          wake_q  <= 1'b1;
          take_q  <= irq_act_i & ~primask_i;
        end
      end else if (wfi_ok) begin
        sleep_q <= 1'b1;
        mode_q  <= MODE_WFI;
        deep_q  <= ctrl_i.deep;
      end else if (wfe_ok) begin
        sleep_q <= 1'b1;
        mode_q  <= MODE_WFE;
        deep_q  <= ctrl_i.deep;
      end
    end
  end

  // event latch: a wait-for-event request always consumes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else if (!sleep_q && wfe_req) evt_q <= 1'b0;
    else if (evt_in_i && !(sleep_q && mode_q == MODE_WFE)) evt_q <= 1'b1;
  end

  assign sleep_req_o = sleep_q;
  assign deep_o      = sleep_q & deep_q;
  assign wake_o      = wake_q;
  assign take_irq_o  = take_q;

  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  assert_wake_ends_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!sleep_req_o && $past(sleep_req_o)));
  assert_refuse_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_req_o && irq_act_i) |=> !sleep_req_o);
  assert_wfi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && mode_q == MODE_WFI && !irq_act_i) |=> sleep_req_o);
  assert_take_with_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> wake_o);
  assert_deep_only_asleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    deep_o |-> sleep_req_o);
  assert_latch_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_q && wfe_i && !wfi_req) |=> !evt_q);
endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl
  import csl_pkg::*;
#(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfi_i,
  input  logic              wfe_i,
  input  logic              exc_ret_i,
  input  logic [NLINES-1:0] irq_pend_i,
  input  logic [NLINES-1:0] irq_en_i,
  input  logic              ext_evt_i,
  input  logic              primask_i,
  input  logic              ctrl_wr_i,
  input  logic [2:0]        ctrl_wdata_i,
  output logic              sleep_req_o,
  output logic              deep_o,
  output logic              wake_o,
  output logic              take_irq_o
);
  ctrl_t ctrl;
  logic  irq_act, evt_in;

  csl_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctrl_wr_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl)
  );

  csl_wake_detect #(.NLINES(NLINES)) u_detect (
    .clk           (clk),
    .rst_n         (rst_n),
    .pend_i        (irq_pend_i),
    .en_i          (irq_en_i),
    .ext_evt_i     (ext_evt_i),
    .sev_on_pend_i (ctrl.sev_on_pend),
    .irq_act_o     (irq_act),
    .evt_in_o      (evt_in)
  );

  csl_sleep_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wfi_i       (wfi_i),
    .wfe_i       (wfe_i),
    .exc_ret_i   (exc_ret_i),
    .ctrl_i      (ctrl),
    .irq_act_i   (irq_act),
    .evt_in_i    (evt_in),
    .primask_i   (primask_i),
    .sleep_req_o (sleep_req_o),
    .deep_o      (deep_o),
    .wake_o      (wake_o),
    .take_irq_o  (take_irq_o)
  );
endmodule

// File: tb/core_sleep_ctrl_test.sv
module core_sleep_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfi_i = 0, wfe_i = 0, exc_ret_i = 0, ext_evt_i = 0, primask_i = 0;
  logic [7:0] irq_pend_i = '0, irq_en_i = '0;
  logic       ctrl_wr_i = 0;
  logic [2:0] ctrl_wdata_i = '0;
  logic       sleep_req_o, deep_o, wake_o, take_irq_o;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;

  core_sleep_ctrl #(.NLINES(8)) uut (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi_i), .wfe_i(wfe_i), .exc_ret_i(exc_ret_i),
    .irq_pend_i(irq_pend_i), .irq_en_i(irq_en_i), .ext_evt_i(ext_evt_i),
    .primask_i(primask_i), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .sleep_req_o(sleep_req_o), .deep_o(deep_o), .wake_o(wake_o), .take_irq_o(take_irq_o)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic set_ctrl(logic [2:0] v);
    ctrl_wr_i = 1; ctrl_wdata_i = v; tick(); ctrl_wr_i = 0;
  endtask

  task automatic do_wfi(); wfi_i = 1; tick(); wfi_i = 0; endtask
  task automatic do_wfe(); wfe_i = 1; tick(); wfe_i = 0; endtask

  // wake through an enabled pending line, check pulse and sleep drop
  task automatic wake_irq(string req, int line, logic exp_take);
    irq_pend_i[line] = 1; irq_en_i[line] = 1; tick();
    chk(req, "wake_o on irq", wake_o, 1'b1);
    chk(req, "sleep_req_o drops", sleep_req_o, 1'b0);
    chk(req, "take_irq_o", take_irq_o, exp_take);
    irq_pend_i = '0; irq_en_i = '0; tick();
    chk("R9", "wake_o one cycle", wake_o, 1'b0);
  endtask

  task automatic t_reset();
    chk("R2", "sleep after reset", sleep_req_o, 1'b0);
    chk("R2", "deep after reset", deep_o, 1'b0);
    chk("R2", "wake after reset", wake_o, 1'b0);
    chk("R2", "take after reset", take_irq_o, 1'b0);
  endtask

  task automatic t_deep();
    do_wfi();
    chk("R2", "wfi enters sleep", sleep_req_o, 1'b1);
    chk("R1", "deep clear after reset", deep_o, 1'b0);
    wake_irq("R10", 0, 1'b1);
    set_ctrl(3'b100);
    do_wfi();
    chk("R11", "deep_o set while asleep", deep_o, 1'b1);
    irq_pend_i[0] = 1; irq_en_i[0] = 1; tick();
    chk("R11", "deep_o low on wake", deep_o, 1'b0);
    irq_pend_i = '0; irq_en_i = '0; tick();
    set_ctrl(3'b000);
  endtask

  task automatic t_wfi_ignores();
    do_wfi();
    irq_pend_i[1] = 1; tick(); tick();
    chk("R3", "disabled pending keeps sleep", sleep_req_o, 1'b1);
    chk("R3", "no wake on disabled pending", wake_o, 1'b0);
    irq_pend_i = '0;
    ext_evt_i = 1; tick(); ext_evt_i = 0; tick();
    chk("R3", "event keeps wfi sleep", sleep_req_o, 1'b1);
    wake_irq("R3", 2, 1'b1);
    do_wfe();
    chk("R8", "latched event makes wfe return", sleep_req_o, 1'b0);
    do_wfe();
    chk("R8", "second wfe sleeps", sleep_req_o, 1'b1);
    ext_evt_i = 1; tick(); ext_evt_i = 0;
    chk("R4", "event wakes wfe", wake_o, 1'b1);
    chk("R4", "no take on event wake", take_irq_o, 1'b0);
    tick();
    chk("R9", "wake_o one cycle after event", wake_o, 1'b0);
  endtask

  task automatic t_wfe_irq();
    do_wfe();
    chk("R4", "wfe sleeps", sleep_req_o, 1'b1);
    wake_irq("R4", 3, 1'b1);
  endtask

  task automatic t_sev();
    do_wfe();
    irq_pend_i[4] = 1; tick(); tick();
    chk("R5", "no sev: disabled pend keeps sleep", sleep_req_o, 1'b1);
    irq_pend_i = '0; tick();
    ext_evt_i = 1; tick(); ext_evt_i = 0; tick();
    set_ctrl(3'b001);
    do_wfe();
    chk("R5", "wfe sleeps with sev", sleep_req_o, 1'b1);
    irq_pend_i[4] = 1; tick();
    chk("R5", "sev wake on disabled pend", wake_o, 1'b1);
    chk("R5", "sev wake takes no irq", take_irq_o, 1'b0);
    irq_pend_i = '0; tick();
    irq_pend_i[5] = 1; tick(); irq_pend_i = '0; tick();
    do_wfe();
    chk("R5", "sev latched while running", sleep_req_o, 1'b0);
    set_ctrl(3'b000);
  endtask

  task automatic t_exit();
    exc_ret_i = 1; tick(); exc_ret_i = 0;
    chk("R6", "exc ret ignored without flag", sleep_req_o, 1'b0);
    set_ctrl(3'b010);
    exc_ret_i = 1; tick(); exc_ret_i = 0;
    chk("R6", "exc ret enters sleep", sleep_req_o, 1'b1);
    ext_evt_i = 1; tick(); ext_evt_i = 0; tick();
    chk("R6", "exit sleep acts as wfi", sleep_req_o, 1'b1);
    wake_irq("R6", 6, 1'b1);
    set_ctrl(3'b000);
    do_wfe();
  endtask

  task automatic t_refuse();
    irq_pend_i[0] = 1; irq_en_i[0] = 1;
    do_wfi();
    chk("R7", "wfi refused while pending", sleep_req_o, 1'b0);
    chk("R7", "no wake on refusal", wake_o, 1'b0);
    do_wfe();
    chk("R7", "wfe refused while pending", sleep_req_o, 1'b0);
    irq_pend_i = '0; irq_en_i = '0; tick();
  endtask

  task automatic t_primask();
    do_wfi();
    primask_i = 1;
    irq_pend_i[7] = 1; irq_en_i[7] = 1; tick();
    chk("R10", "masked wake occurs", wake_o, 1'b1);
    chk("R10", "masked wake takes no irq", take_irq_o, 1'b0);
    irq_pend_i = '0; irq_en_i = '0; primask_i = 0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1; tick();
    t_deep();
    t_wfi_ignores();
    t_wfe_irq();
    t_sev();
    t_exit();
    t_refuse();
    t_primask();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule